// File: doc/BRIEF.md
# Burst Column Address Generator

This block walks the column addresses of one memory burst. A single-cycle start pulse captures an 8-bit start column, a length code and an ordering bit. From the next clock the block presents one column per cycle, with a valid flag, until the programmed number of beats has been issued. A last flag marks the final beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside an aligned window of that size. Inside the window the low address bits step either in sequential order (add and wrap) or in interleaved order (XOR with the beat index). In full-page mode the whole column counts upward through all 256 values and wraps around until a terminate input stops it. Terminate can also cut a fixed burst short. A new start pulse always begins a new burst, even in the middle of a running one.

Top module: `burstColGen`

## Requirements
- R1: While reset is held and after reset, `colValid` and `colLast` are 0 until a start pulse is sampled.
- R2: When `startPulse` is sampled high on a rising edge, the next cycle shows `colValid`=1 and `colOut` equal to the captured `startCol`.
- R3: `lenCode` values 0, 1, 2 and 3 give bursts of exactly 1, 2, 4 and 8 valid beats, one beat per clock. Any code with bit 2 set selects full-page mode.
- R4: With `burstType`=0 (sequential), beat k of a burst of length BL carries the start column with its low log2(BL) bits replaced by (start low bits + k) mod BL. The upper bits are unchanged.
- R5: With `burstType`=1 (interleave), beat k of a fixed burst carries the start column with its low log2(BL) bits replaced by (start low bits XOR k). The upper bits are unchanged.
- R6: In full-page mode the whole 8-bit column increases by one per beat and wraps from 255 to 0. `burstType` has no effect, and the burst runs until terminated or restarted.
- R7: `colLast` is 1 exactly on the final beat of a fixed-length burst. It is never 1 in full-page mode or while `colValid` is 0.
- R8: When `term` is sampled high during a valid beat (and no start is sampled), that beat is the last one: `colValid` is 0 in the next cycle. `term` sampled while idle has no effect.
- R9: A start pulse sampled during a running burst begins the new burst in the next cycle. A start pulse takes precedence over a `term` sampled on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| startPulse | input | 1 | Begin a burst with the values on the next three inputs |
| startCol | input | 8 | First column of the burst |
| lenCode | input | 3 | Burst length code (0..3 fixed, bit 2 set = full page) |
| burstType | input | 1 | 0 sequential, 1 interleave |
| term | input | 1 | Stop the running burst after the current beat |
| colOut | output | 8 | Column address of the current beat |
| colValid | output | 1 | Current beat is valid |
| colLast | output | 1 | Current beat ends a fixed-length burst |

## Verification
On every cycle the assertions check that a start loads its column, that terminate and last both end the burst, that the upper column bits stay fixed during a fixed burst, that a full-page burst steps by one with no last flag, and that last never appears without valid. The exact beat ordering inside the window, for sequential and interleaved ordering, can only be shown by the bench's reference model. The same holds for the beat count of each length code, the 255-to-0 wrap, restarts in the middle of a burst and a start that coincides with terminate.

// File: rtl/burstColPkg.sv
package burstColPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new burst
    logic step;   // advance to the next beat
    logic stop;   // end the running burst
  } burstCtl_t;

  // Window mask for a fixed length code: BL-1
  function automatic int unsigned winMaskOf(input int unsigned sizeLog);
    return (32'd1 << sizeLog) - 32'd1;
  endfunction

endpackage

// File: rtl/burstColCtrl.sv
module burstColCtrl
  import burstColPkg::*;
#(
  parameter int COL_W = 8,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             term,
  output burstCtl_t        ctl,
  output logic             colValid,
  output logic             colLast
);

  localparam int SIZE_W = LEN_W - 1;

  logic             runQ;
  logic             fullPageQ;
  logic [COL_W-1:0] beatsLeftQ;
  logic             finalBeat;
  logic             reqFullPage;
  logic [COL_W-1:0] reqBeatsLeft;

  assign reqFullPage  = lenCode[LEN_W-1];
  assign reqBeatsLeft = COL_W'(winMaskOf(32'(lenCode[SIZE_W-1:0])));

  assign finalBeat = runQ && !fullPageQ && (beatsLeftQ == '0);

  always_comb begin
    ctl      = '0;
    ctl.load = startPulse;
    ctl.stop = !startPulse && runQ && (term || finalBeat);
    ctl.step = !startPulse && runQ && !term && !finalBeat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ       <= 1'b0;
      fullPageQ  <= 1'b0;
      beatsLeftQ <= '0;
    end else if (ctl.load) begin
      runQ       <= 1'b1;
      fullPageQ  <= reqFullPage;
      beatsLeftQ <= reqFullPage ? '0 : reqBeatsLeft;
    end else if (ctl.stop) begin
      runQ <= 1'b0;
    end else if (ctl.step && !fullPageQ) begin
      beatsLeftQ <= beatsLeftQ - 1'b1;
    end
  end

  assign colValid = runQ;
  assign colLast  = finalBeat;

endmodule

// File: rtl/burstColPath.sv
module burstColPath
  import burstColPkg::*;
#(
  parameter int COL_W = 8,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  burstCtl_t        ctl,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             burstType,
  output logic [COL_W-1:0] colOut
);

  localparam int SIZE_W = LEN_W - 1;

  logic [COL_W-1:0] baseColQ;
  logic [COL_W-1:0] winMaskQ;
  logic [COL_W-1:0] offsetQ;
  logic             interleaveQ;
  logic             reqFullPage;
  logic [COL_W-1:0] seqLow;
  logic [COL_W-1:0] ilvLow;

  assign reqFullPage = lenCode[LEN_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseColQ    <= '0;
      winMaskQ    <= '0;
      offsetQ     <= '0;
      interleaveQ <= 1'b0;
    end else if (ctl.load) begin
      baseColQ    <= startCol;
      winMaskQ    <= reqFullPage ? '1 : COL_W'(winMaskOf(32'(lenCode[SIZE_W-1:0])));
      offsetQ     <= '0;
      interleaveQ <= burstType && !reqFullPage;
    end else if (ctl.step) begin
      offsetQ <= offsetQ + 1'b1;
    end
  end

  // Low bits inside the window, upper bits pass through from the base
  assign seqLow = (baseColQ + offsetQ) & winMaskQ;
  assign ilvLow = (baseColQ ^ offsetQ) & winMaskQ;
  assign colOut = (baseColQ & ~winMaskQ) | (interleaveQ ? ilvLow : seqLow);

endmodule

// File: rtl/burstColGen.sv
module burstColGen
  import burstColPkg::*;
#(
  parameter int COL_W = 8,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             burstType,
  input  logic             term,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             colLast
);

  burstCtl_t ctl;

  burstColCtrl #(.COL_W(COL_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .lenCode(lenCode),
    .term(term), .ctl(ctl), .colValid(colValid), .colLast(colLast)
  );

  burstColPath #(.COL_W(COL_W), .LEN_W(LEN_W)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startCol(startCol),
    .lenCode(lenCode), .burstType(burstType), .colOut(colOut)
  );

endmodule

// File: rtl/burstColChk.sv
module burstColChk
  import burstColPkg::*;
#(
  parameter int COL_W = 8,
  parameter int LEN_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic [COL_W-1:0] startCol,
  input logic [LEN_W-1:0] lenCode,
  input logic             term,
  input logic [COL_W-1:0] colOut,
  input logic             colValid,
  input logic             colLast
);

  logic             chkFull;
  logic [COL_W-1:0] chkMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chkFull <= 1'b0;
      chkMask <= '0;
    end else if (startPulse) begin
      chkFull <= lenCode[LEN_W-1];
      chkMask <= lenCode[LEN_W-1] ? '1 : COL_W'(winMaskOf(32'(lenCode[LEN_W-2:0])));
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rstN |=> !colValid && !colLast); // R1
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> colValid && colOut == $past(startCol)); // R2
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    colValid && $past(colValid) && !$past(startPulse) && !chkFull
    |-> ((colOut ^ $past(colOut)) & ~chkMask) == '0); // R4
  AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    colValid && $past(colValid) && !$past(startPulse) && chkFull
    |-> colOut == $past(colOut) + 1'b1); // R6
  AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (!rstN)
    chkFull && colValid |-> !colLast); // R7
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rstN)
    colLast |-> colValid); // R7
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    colLast && !startPulse |=> !colValid); // R3
  AST_TERM_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    colValid && term && !startPulse |=> !colValid); // R8

endmodule

bind burstColGen burstColChk #(.COL_W(COL_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .startCol(startCol),
  .lenCode(lenCode), .term(term), .colOut(colOut), .colValid(colValid),
  .colLast(colLast)
);

// File: tb/burstColGen_tb.sv
module burstColGen_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic       startPulse;
  logic [7:0] startCol;
  logic [2:0] lenCode;
  logic       burstType;
  logic       term;
  logic [7:0] colOut;
  logic       colValid;
  logic       colLast;

  int    errs = 0;
  int    checks = 0;
  bit    running = 0;
  bit    done = 0;
  string tag = "R1";

  // Behavioural reference state
  bit mAct = 0;
  int mBase, mK, mLen;
  bit mFull, mIlv;

  always #5 clk = ~clk;

  burstColGen u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startCol(startCol),
    .lenCode(lenCode), .burstType(burstType), .term(term),
    .colOut(colOut), .colValid(colValid), .colLast(colLast)
  );

  task automatic check(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  function automatic int expCol();
    int lowS, upper;
    if (mFull) return (mBase + mK) % 256;
    upper = (mBase / mLen) * mLen;
    lowS  = mBase % mLen;
    if (mIlv) return upper + (lowS ^ mK);
    return upper + ((lowS + mK) % mLen);
  endfunction

  // Reference model advances on each edge
  always @(posedge clk) begin
    if (!rstN) mAct = 0;
    else if (startPulse) begin
      mAct = 1; mBase = startCol; mK = 0;
      mFull = lenCode[2];
      mIlv = burstType && !mFull;
      mLen = mFull ? 256 : (1 << lenCode[1:0]);
    end else if (mAct) begin
      if (term || (!mFull && mK == mLen - 1)) mAct = 0;
      else mK = mK + 1;
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (running && !done) begin
      bit eLast;
      eLast = mAct && !mFull && (mK == mLen - 1);
      check(colValid == mAct, {tag, " valid"}, colValid, mAct);
      check(colLast == eLast, {tag, " R7 last"}, colLast, eLast);
      if (mAct) check(colOut == 8'(expCol()), {tag, " column"}, colOut, expCol());
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic go(input int col, input int code, input bit typ, input string t);
    tag = t;
    startCol = 8'(col); lenCode = 3'(code); burstType = typ;
    startPulse = 1'b1;
    idle(1);
    startPulse = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; startPulse = 0; startCol = 0; lenCode = 0; burstType = 0; term = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(colValid == 0, "R1 valid in reset", colValid, 0);
    check(colLast == 0, "R1 last in reset", colLast, 0);
    @(posedge clk); #2;
    rstN = 1'b1;
    running = 1;
    tag = "R1";
    idle(2);

    go(8'h5D, 2, 0, "R2 R4");       idle(6);
    go(8'h2B, 3, 1, "R5");          idle(10);
    go(8'h2B, 3, 0, "R4");          idle(10);
    go(8'h11, 0, 1, "R3 len1");     idle(3);
    go(8'h11, 1, 0, "R3 len2");     idle(4);
    go(8'h36, 1, 1, "R3 R5 len2");  idle(4);
    go(8'h9E, 2, 1, "R5 len4");     idle(6);

    go(8'hFC, 7, 1, "R6 wrap");     idle(9);
    tag = "R8 full term";
    term = 1; idle(1); term = 0; idle(3);

    tag = "R8 idle term";
    term = 1; idle(2); term = 0; idle(2);

    go(8'hF8, 4, 0, "R6 long");     idle(300);
    tag = "R8 stop long";
    term = 1; idle(1); term = 0; idle(3);

    go(8'h33, 3, 1, "R8 cut");      idle(2);
    term = 1; idle(1); term = 0; idle(4);

    go(8'h47, 3, 0, "R9 restart");  idle(3);
    go(8'h90, 2, 1, "R9 second");   idle(6);

    term = 1;
    go(8'h20, 2, 0, "R9 start wins");
    term = 0; idle(6);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule